// File: doc/BRIEF.md
# Serial Stereo Audio Receiver with Digital-Silence Mute

This block is a slave receiver for a three-wire serial audio link: a bit clock, a word clock and a data line. It runs entirely on the bit clock and rebuilds the left and right two's-complement samples from the MSB-first serial stream. A format pin chooses between I2S framing, where the first data bit arrives one bit clock after the word clock changes, and left-justified framing, where the first data bit arrives in the same bit clock as the change. Either 32 or 64 bit clocks per stereo frame are accepted without configuration. A length code picks a 16, 20, 24 or 32-bit word.

Each completed stereo pair is presented on two 32-bit outputs, aligned to the MSB with zeros in the unused LSBs, together with a one-cycle valid strobe. A silence detector watches the completed frames and raises a mute request once both channels have been zero for 1024 frames in a row. The request drops on the first frame that carries any non-zero data. Moving the samples into the system-clock domain and filtering them belong to the stage that consumes these outputs.

The framing control is a three-state machine. HUNT is entered at reset; it leaves for LEFT on the first left-word boundary (transition *lock*). LEFT, on a right-word boundary, stores the left word and moves to RIGHT (transition *half*); on another left-word boundary it restarts the left word (transition *resync*). RIGHT, on a left-word boundary, publishes the pair and returns to LEFT (transition *publish*); on a second right-word boundary it drops back to HUNT (transition *lost*).

Top module: `i2s_lj_rx`

## Requirements
- R1: The data line is sampled on the rising edge of the bit clock; words arrive MSB first, and the 32-bit sample outputs hold each received word unaltered in two's complement.
- R2: With `fmt_lj` = 0 (I2S), a word's MSB is the bit sampled one bit clock after the sampled word clock changes level, and word clock low marks the left channel.
- R3: With `fmt_lj` = 1 (left-justified), a word's MSB is the bit sampled at the first edge where the word clock shows its new level, and word clock high marks the left channel.
- R4: `word_len` encodes 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits; the word is placed from bit 31 downward, every bit below it reads zero, and serial bits arriving after the last word bit within a slot have no effect on the outputs.
- R5: Both 16 and 32 bit clocks per channel slot are accepted with no setting; when the slot holds fewer bits than the word length, the bits never received read as zero.
- R6: `frame_valid` pulses for exactly one cycle per stereo frame; it rises one bit clock after the edge at which the next left word begins (that edge for left-justified, the edge after it for I2S), both samples change only together with this pulse, and one pulse is produced for each complete left-then-right pair.
- R7: After reset both samples and `mute_req` read zero and `frame_valid` is low; no pulse is produced until a full left word and then a full right word have been received.
- R8: `mute_req` goes high one cycle after the strobe of the 1024th consecutive frame whose two samples (after R4 masking) are both zero, and stays high while such frames continue.
- R9: A frame with any non-zero bit in either sample clears the zero-frame count, and `mute_req` is low from the cycle after that frame's strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Serial bit clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_sel | input | 1 | Word clock, marks the channel of the current slot |
| ser_data | input | 1 | Serial audio data, MSB first |
| fmt_lj | input | 1 | 0 selects I2S framing, 1 selects left-justified framing |
| word_len | input | 2 | Word length code: 0 = 16, 1 = 20, 2 = 24, 3 = 32 bits |
| left_sample | output | 32 | Left sample, MSB aligned |
| right_sample | output | 32 | Right sample, MSB aligned |
| frame_valid | output | 1 | One-cycle strobe when a new stereo pair is on the outputs |
| mute_req | output | 1 | Request for analog mute after a long digitally silent run |

## Verification
A wrong bit counter or a wrong boundary choice shows at the very next strobe as a sample shifted by one bit, with its MSB lost or an LSB doubled, so every frame compared exposes it within one frame time. A framing machine stuck in the wrong state shows as a missing or extra strobe, or a left and right pair swapped, at the next frame boundary. A silence counter that is off by one is only visible at the 1024th zero frame, so the bench runs a full silent stretch and checks the request one cycle after every strobe on both sides of that edge, and again when speech resumes.

// File: rtl/i2s_lj_rx_pkg.sv
package i2s_lj_rx_pkg;

    // Framing machine states
    typedef enum logic [1:0] {
        RX_HUNT  = 2'd0,
        RX_LEFT  = 2'd1,
        RX_RIGHT = 2'd2
    } rx_state_t;

    // Word length codes on the word_len pins
    typedef enum logic [1:0] {
        WL_16 = 2'd0,
        WL_20 = 2'd1,
        WL_24 = 2'd2,
        WL_32 = 2'd3
    } wlen_t;

    // Number of data bits kept for a word length code
    function automatic logic [5:0] wlen_bits(input logic [1:0] code);
        logic [5:0] n;
        unique case (wlen_t'(code))
            WL_16:   n = 6'd16;
            WL_20:   n = 6'd20;
            WL_24:   n = 6'd24;
            WL_32:   n = 6'd32;
            default: n = 6'd32;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/i2s_lj_rx_framer.sv
// Keeps a short history of the word clock and reports where a new word
// starts and which channel it belongs to, for both framing formats.
module i2s_lj_rx_framer (
    input  logic clk,
    input  logic rst_n,
    input  logic word_sel,
    input  logic fmt_lj,
    output logic word_start,
    output logic start_left
);

    localparam int WARM_EDGES = 2;
    localparam int WARM_W     = $clog2(WARM_EDGES + 1);

    logic              ws_q;
    logic              ws_qq;
    logic [WARM_W-1:0] warm_q;
    logic              ready;
    logic              lj_edge;
    logic              i2s_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ws_q   <= 1'b0;
            ws_qq  <= 1'b0;
            warm_q <= '0;
        end else begin
            ws_q  <= word_sel;
            ws_qq <= ws_q;
            if (warm_q != WARM_W'(WARM_EDGES)) begin
                warm_q <= warm_q + 1'b1;
            end
        end
    end

    // History is only trusted once it holds real samples of the word clock
    assign ready    = (warm_q == WARM_W'(WARM_EDGES));
    // Left-justified: MSB sits on the edge where the new level is first seen
    assign lj_edge  = word_sel ^ ws_q;
    // I2S: MSB sits one edge later
    assign i2s_edge = ws_q ^ ws_qq;

    always_comb begin
        if (fmt_lj) begin
            word_start = ready && lj_edge;
            start_left = word_sel;
        end else begin
            word_start = ready && i2s_edge;
            start_left = ~ws_q;
        end
    end

endmodule

// File: rtl/i2s_lj_rx_shifter.sv
// Collects serial bits of the current word into an MSB-aligned register,
// keeping only as many bits as the word length asks for.
module i2s_lj_rx_shifter #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ser_data,
    input  logic                word_start,
    input  logic [1:0]          word_len,
    output logic [SAMPLE_W-1:0] acc_word
);

    import i2s_lj_rx_pkg::*;

    localparam int IDX_W = $clog2(SAMPLE_W) + 1;

    logic [SAMPLE_W-1:0] acc_q;
    logic [SAMPLE_W-1:0] acc_d;
    logic [IDX_W-1:0]    idx_q;
    logic [IDX_W-1:0]    idx_d;
    logic [IDX_W-1:0]    keep;

    assign keep = IDX_W'(wlen_bits(word_len));

    always_comb begin
        acc_d = acc_q;
        idx_d = idx_q;
        if (word_start) begin
            acc_d               = '0;
            acc_d[SAMPLE_W-1]   = ser_data;
            idx_d               = IDX_W'(1);
        end else if (idx_q < IDX_W'(SAMPLE_W)) begin
            idx_d = idx_q + 1'b1;
            if (idx_q < keep) begin
                acc_d[SAMPLE_W-1-int'(idx_q)] = ser_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            idx_q <= '0;
        end else begin
            acc_q <= acc_d;
            idx_q <= idx_d;
        end
    end

    assign acc_word = acc_q;

endmodule

// File: rtl/i2s_lj_rx_fsm.sv
// Framing machine: pairs a left word with the following right word and
// publishes the pair with a strobe.
module i2s_lj_rx_fsm #(
    parameter int SAMPLE_W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_start,
    input  logic                start_left,
    input  logic [SAMPLE_W-1:0] acc_word,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                frame_valid
);

    import i2s_lj_rx_pkg::*;

    rx_state_t           state_q;
    rx_state_t           state_d;
    logic                take_left;
    logic                take_frame;
    logic [SAMPLE_W-1:0] hold_q;
    logic [SAMPLE_W-1:0] left_q;
    logic [SAMPLE_W-1:0] right_q;
    logic                valid_q;

    // Next state and transition actions
    always_comb begin
        state_d    = state_q;
        take_left  = 1'b0;
        take_frame = 1'b0;
        unique case (state_q)
            RX_HUNT: begin
                if (word_start && start_left) begin
                    state_d = RX_LEFT;            // lock
                end
            end
            RX_LEFT: begin
                if (word_start) begin
                    if (start_left) begin
                        state_d = RX_LEFT;        // resync
                    end else begin
                        state_d   = RX_RIGHT;     // half
                        take_left = 1'b1;
                    end
                end
            end
            RX_RIGHT: begin
                if (word_start) begin
                    if (start_left) begin
                        state_d    = RX_LEFT;     // publish
                        take_frame = 1'b1;
                    end else begin
                        state_d = RX_HUNT;        // lost
                    end
                end
            end
            default: state_d = RX_HUNT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RX_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q  <= '0;
            left_q  <= '0;
            right_q <= '0;
            valid_q <= 1'b0;
        end else begin
            if (take_left) begin
                hold_q <= acc_word;
            end
            if (take_frame) begin
                left_q  <= hold_q;
                right_q <= acc_word;
            end
            valid_q <= take_frame;
        end
    end

    assign left_sample  = left_q;
    assign right_sample = right_q;
    assign frame_valid  = valid_q;

endmodule

// File: rtl/i2s_lj_rx_silence.sv
// Counts consecutive all-zero stereo frames and requests a mute after a
// long silent run.
module i2s_lj_rx_silence #(
    parameter int SAMPLE_W    = 32,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_valid,
    input  logic [SAMPLE_W-1:0] left_sample,
    input  logic [SAMPLE_W-1:0] right_sample,
    output logic                mute_req
);

    localparam int CNT_W = $clog2(ZERO_FRAMES + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             mute_q;
    logic             silent;

    assign silent = ~(|left_sample) & ~(|right_sample);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mute_q <= 1'b0;
        end else if (frame_valid) begin
            if (silent) begin
                if (cnt_q != CNT_W'(ZERO_FRAMES)) begin
                    cnt_q <= cnt_q + 1'b1;
                end
                mute_q <= (cnt_q >= CNT_W'(ZERO_FRAMES - 1));
            end else begin
                cnt_q  <= '0;
                mute_q <= 1'b0;
            end
        end
    end

    assign mute_req = mute_q;

endmodule

// File: rtl/i2s_lj_rx.sv
// Serial stereo audio receiver, bit-clock domain.
module i2s_lj_rx #(
    parameter int SAMPLE_W    = 32,
    parameter int ZERO_FRAMES = 1024
) (
    input  logic                bclk,
    input  logic                rst_n,
    input  logic                word_sel,
    input  logic                ser_data,
    input  logic                fmt_lj,
    input  logic [1:0]          word_len,
    output logic [SAMPLE_W-1:0] left_sample,
    output logic [SAMPLE_W-1:0] right_sample,
    output logic                frame_valid,
    output logic                mute_req
);

    logic                word_start;
    logic                start_left;
    logic [SAMPLE_W-1:0] acc_word;

    i2s_lj_rx_framer u_framer (
        .clk        (bclk),
        .rst_n      (rst_n),
        .word_sel   (word_sel),
        .fmt_lj     (fmt_lj),
        .word_start (word_start),
        .start_left (start_left)
    );

    i2s_lj_rx_shifter #(
        .SAMPLE_W (SAMPLE_W)
    ) u_shifter (
        .clk        (bclk),
        .rst_n      (rst_n),
        .ser_data   (ser_data),
        .word_start (word_start),
        .word_len   (word_len),
        .acc_word   (acc_word)
    );

    i2s_lj_rx_fsm #(
        .SAMPLE_W (SAMPLE_W)
    ) u_fsm (
        .clk          (bclk),
        .rst_n        (rst_n),
        .word_start   (word_start),
        .start_left   (start_left),
        .acc_word     (acc_word),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .frame_valid  (frame_valid)
    );

    i2s_lj_rx_silence #(
        .SAMPLE_W    (SAMPLE_W),
        .ZERO_FRAMES (ZERO_FRAMES)
    ) u_silence (
        .clk          (bclk),
        .rst_n        (rst_n),
        .frame_valid  (frame_valid),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .mute_req     (mute_req)
    );

endmodule

// File: rtl/i2s_lj_rx_chk.sv
module i2s_lj_rx_chk #(
    parameter int SAMPLE_W = 32
) (
    input logic                bclk,
    input logic                rst_n,
    input logic [1:0]          word_len,
    input logic [SAMPLE_W-1:0] left_sample,
    input logic [SAMPLE_W-1:0] right_sample,
    input logic                frame_valid,
    input logic                mute_req
);

    AST_VALID_ONE_CYCLE: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid |=> !frame_valid); // R6

    AST_LEFT_HELD: assert property (@(posedge bclk) disable iff (!rst_n)
        !frame_valid |-> $stable(left_sample)); // R6

    AST_RIGHT_HELD: assert property (@(posedge bclk) disable iff (!rst_n)
        !frame_valid |-> $stable(right_sample)); // R6

    AST_SHORT_WORD_PAD: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_valid && word_len == 2'd0) |->
            (left_sample[15:0] == 16'd0 && right_sample[15:0] == 16'd0)); // R4

    AST_MUTE_AFTER_STROBE: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(mute_req) |-> $past(frame_valid)); // R8

    AST_MUTE_CLEARS: assert property (@(posedge bclk) disable iff (!rst_n)
        (frame_valid && ((|left_sample) || (|right_sample))) |=> !mute_req); // R9

endmodule

bind i2s_lj_rx i2s_lj_rx_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .bclk         (bclk),
    .rst_n        (rst_n),
    .word_len     (word_len),
    .left_sample  (left_sample),
    .right_sample (right_sample),
    .frame_valid  (frame_valid),
    .mute_req     (mute_req)
);

// File: tb/sim_i2s_lj_rx.sv
`timescale 1ns/1ps
module sim_i2s_lj_rx;

    localparam int MAX_FR = 1100;
    localparam int ZRUN   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        word_sel = 1'b0;
    logic        ser_data = 1'b0;
    logic        fmt_lj = 1'b0;
    logic [1:0]  word_len = 2'd3;
    logic [31:0] left_sample;
    logic [31:0] right_sample;
    logic        frame_valid;
    logic        mute_req;

    always #2 clk = ~clk;

    i2s_lj_rx u0 (
        .bclk         (clk),
        .rst_n        (rst_n),
        .word_sel     (word_sel),
        .ser_data     (ser_data),
        .fmt_lj       (fmt_lj),
        .word_len     (word_len),
        .left_sample  (left_sample),
        .right_sample (right_sample),
        .frame_valid  (frame_valid),
        .mute_req     (mute_req)
    );

    int          n_cmp = 0;
    int          n_bad = 0;
    logic [31:0] exp_l [0:MAX_FR-1];
    logic [31:0] exp_r [0:MAX_FR-1];
    int          n_exp = 0;
    int          n_got = 0;
    int          zc = 0;
    bit          exp_mute = 1'b0;
    bit          mute_pend = 1'b0;
    bit          prev_mute = 1'b0;
    bit          prev_bit = 1'b0;
    bit          done = 1'b0;
    string       cur_tag = "R1";

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, expv, $time);
        end
    endtask

    function automatic int keep_of(input logic [1:0] wl);
        case (wl)
            2'd0:    return 16;
            2'd1:    return 20;
            2'd2:    return 24;
            default: return 32;
        endcase
    endfunction

    // R4 / R5: MSB-aligned, only min(word length, slot) bits survive
    function automatic logic [31:0] exp_word(input logic [31:0] w, input logic [1:0] wl,
                                             input int slot);
        int n;
        n = (keep_of(wl) < slot) ? keep_of(wl) : slot;
        return w & (32'hFFFF_FFFF << (32 - n));
    endfunction

    // Output monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (mute_pend) begin
                chk(mute_req == exp_mute, (prev_mute && !exp_mute) ? "R9" : "R8",
                    {31'd0, mute_req}, {31'd0, exp_mute});
                mute_pend = 1'b0;
            end
            if (frame_valid) begin
                if (n_got < n_exp) begin
                    chk(left_sample == exp_l[n_got], cur_tag, left_sample, exp_l[n_got]);
                    chk(right_sample == exp_r[n_got], cur_tag, right_sample, exp_r[n_got]);
                end else begin
                    chk(1'b0, "R7", 32'(n_got), 32'(n_exp));
                end
                prev_mute = exp_mute;
                if (left_sample == 32'd0 && right_sample == 32'd0) begin
                    if (zc < ZRUN) zc++;
                end else begin
                    zc = 0;
                end
                exp_mute  = (zc >= ZRUN);
                mute_pend = 1'b1;
                n_got++;
            end
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        n_exp = 0; n_got = 0; zc = 0;
        exp_mute = 1'b0; mute_pend = 1'b0; prev_mute = 1'b0;
        repeat (3) @(negedge clk);
        // R7: reset state
        chk(left_sample == 32'd0, "R7", left_sample, 32'd0);
        chk(right_sample == 32'd0, "R7", right_sample, 32'd0);
        chk({frame_valid, mute_req} == 2'b00, "R7", {30'd0, frame_valid, mute_req}, 32'd0);
        rst_n = 1'b1;
    endtask

    // One bit clock: word clock level and the bit a left-justified sender
    // would put here; I2S delays the data one bit (R2, R3)
    task automatic send_cycle(input logic lv, input logic b);
        @(negedge clk);
        word_sel = lv;
        ser_data = fmt_lj ? b : prev_bit;
        prev_bit = b;
    endtask

    // mode 0: random data, mode 1: silence run with a speech burst
    task automatic run_seq(input logic fmt, input logic [1:0] wl, input int slot,
                           input int nfr, input int mode);
        logic        lv;
        logic [31:0] lw;
        logic [31:0] rw;
        fmt_lj   = fmt;
        word_len = wl;
        prev_bit = 1'b0;
        lv = fmt ? 1'b1 : 1'b0;
        if (slot < keep_of(wl))      cur_tag = "R5";
        else if (keep_of(wl) < 32)   cur_tag = "R4";
        else                         cur_tag = fmt ? "R3" : "R2";
        do_reset();
        for (int i = 0; i < 6; i++) send_cycle(~lv, 1'b0);
        for (int f = 0; f < nfr; f++) begin
            if (mode == 0) begin
                lw = $urandom; rw = $urandom;
            end else if (f < ZRUN + 4) begin
                lw = $urandom & 32'h0000_FFFF;   // below the 16-bit word: ignored
                rw = $urandom & 32'h0000_FFFF;
            end else if (f < ZRUN + 6) begin
                lw = $urandom | 32'h8000_0000;
                rw = $urandom;
            end else begin
                lw = 32'd0; rw = 32'd0;
            end
            exp_l[n_exp] = exp_word(lw, wl, slot);
            exp_r[n_exp] = exp_word(rw, wl, slot);
            n_exp++;
            for (int j = 0; j < slot; j++) send_cycle(lv, lw[31-j]);
            for (int j = 0; j < slot; j++) send_cycle(~lv, rw[31-j]);
        end
        // Begin a left word so the last pair is published
        for (int i = 0; i < 6; i++) send_cycle(lv, 1'b0);
        repeat (3) @(negedge clk);
        // R6: one strobe per complete pair, none extra
        chk(n_got == n_exp, "R6", 32'(n_got), 32'(n_exp));
    endtask

    initial begin
        void'($urandom(32'h0000_5EED));
        // Directed corners (R1 covers all data paths)
        run_seq(1'b0, 2'd3, 32, 6, 0);
        run_seq(1'b1, 2'd3, 32, 6, 0);
        run_seq(1'b0, 2'd0, 32, 6, 0);
        run_seq(1'b1, 2'd1, 32, 6, 0);
        run_seq(1'b1, 2'd2, 16, 6, 0);
        run_seq(1'b0, 2'd3, 16, 6, 0);
        run_seq(1'b0, 2'd2, 32, 6, 0);
        // Constrained random configurations
        for (int k = 0; k < 8; k++) begin
            run_seq(1'($urandom), 2'($urandom), ($urandom % 2) ? 32 : 16, 5, 0);
        end
        // R8 / R9: long silent run, then speech, then silence again
        run_seq(1'b1, 2'd0, 32, ZRUN + 9, 1);
        chk(mute_req == 1'b0, "R9", {31'd0, mute_req}, 32'd0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog R6 actual=%h expected=%h", n_got, n_exp);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule